// File: doc/BRIEF.md
# Indirect Interrupt Redirection Register File

This block holds the programmable state of an I/O interrupt router and presents it to a processor bus through two 32-bit locations. A selector register at bus offset 0x00 names an internal register. A data window at bus offset 0x10 reads or writes the register that the selector names. Behind the window are four kinds of register. The first is a 4-bit identification field. The second is a constant version word. The third is an arbitration word that mirrors the identification field. The last is a table of redirection entries, each 64 bits wide and reached as two 32-bit halves.

Software first writes an index into the selector and then accesses the window. The block protects two hardware-owned status bits in the low half of every entry. After each accepted entry write it emits a one-cycle update pulse that carries the entry number, so that the separate delivery logic can reload its copy of that entry. Read data is registered and returns one cycle after the request, together with a response strobe.

Top module: `irq_route_regfile`

## Requirements
- R1: After reset, the selector reads 0 and the identification field reads 0. For every entry n, the low half reads 0x0001_0000 (mask bit 16 set) and the high half reads 0x0000_0000.
- R2: Only bus offsets 0x00 (selector) and 0x10 (window) are decoded. A write to any other offset changes no state, and a read of any other offset returns 0.
- R3: An access is accepted only when its size is 4 bytes. A write of any other size changes no state, and a read of any other size returns 0.
- R4: For n from 0 to 23, the full 32-bit selector value 0x10+2n addresses bits 31:0 of entry n, and 0x11+2n addresses bits 63:32 of entry n.
- R5: A window write to a low half takes every bit from the written data except bits 12 and 14. Those two bits keep their held value, which is 0 in this block. The high half of the entry is not changed.
- R6: A window write to a high half replaces all 32 bits of that half and leaves the low half unchanged.
- R7: A window write with selector 0x00 stores data bits 27:24. A window read with selector 0x00 or with selector 0x02 returns those 4 bits in positions 27:24 and zeros in every other position.
- R8: A window read with selector 0x01 returns 0x0017_0011. A window write with selector 0x01 changes no state.
- R9: With any selector value outside 0x00 to 0x02 and 0x10 to 0x3F (for example 0x03, 0x0F, 0x40 or 0x1000_0010), a window read returns 0 and a window write changes no state.
- R10: Each accepted window write to entry n raises upd_valid for exactly the next cycle, with upd_index equal to n. No other access raises upd_valid.
- R11: A read at bus offset 0x00 returns the full 32-bit value last written to the selector.
- R12: Every bus read request, accepted or not, gives rvalid and rdata one clock cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Request strobe, one cycle per access |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the access |
| bus_size | input | 3 | Access size in bytes |
| bus_wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, registered |
| rvalid | output | 1 | Read response strobe |
| upd_valid | output | 1 | One-cycle entry update pulse |
| upd_index | output | 5 | Number of the entry that was updated |

## Verification
The bench sweeps every entry through both halves and checks the boundary selectors 0x3F and 0x40. A decoder that is off by one would either alias entry 23 or write a phantom entry. Low-half writes use data with bits 12 and 14 set, which catches a design that lets software overwrite the status bits. The identification register is written with all ones, so an incorrect field width or position shows as stray bits. Writes through unmapped offsets, wrong sizes, the version index and undefined indices are each followed by readbacks and pulse checks, which expose decode leaks that would corrupt state or raise false updates.

// File: rtl/irq_rf_pkg.sv
package irq_rf_pkg;
  typedef enum logic [2:0] {
    K_ID,
    K_VER,
    K_ARB,
    K_ENT_LO,
    K_ENT_HI,
    K_NONE
  } sel_kind_e;
endpackage

// File: rtl/irq_rf_bus_decode.sv
module irq_rf_bus_decode #(
  parameter int ADDR_W   = 8,
  parameter int SIZE_W   = 3,
  parameter int BYTES    = 4,
  parameter logic [ADDR_W-1:0] SEL_OFF = 'h00,
  parameter logic [ADDR_W-1:0] WIN_OFF = 'h10
) (
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [SIZE_W-1:0] bus_size,
  output logic              sel_wr,
  output logic              win_wr,
  output logic              rd_req,
  output logic              rd_sel,
  output logic              rd_win
);
  logic size_ok;
  logic at_sel;
  logic at_win;

  always_comb begin
    size_ok = (bus_size == SIZE_W'(BYTES));
    at_sel  = (bus_addr == SEL_OFF);
    at_win  = (bus_addr == WIN_OFF);
    sel_wr  = bus_valid && bus_write && size_ok && at_sel;
    win_wr  = bus_valid && bus_write && size_ok && at_win;
    rd_req  = bus_valid && !bus_write;
    rd_sel  = rd_req && size_ok && at_sel;
    rd_win  = rd_req && size_ok && at_win;
  end
endmodule

// File: rtl/irq_rf_index_decode.sv
module irq_rf_index_decode
  import irq_rf_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int NUM_ENTRIES = 24,
  parameter logic [DATA_W-1:0] ENT_BASE = 'h10,
  localparam int IDX_W = $clog2(NUM_ENTRIES)
) (
  input  logic [DATA_W-1:0] sel,
  output sel_kind_e         kind,
  output logic [IDX_W-1:0]  ent_idx
);
  localparam logic [DATA_W-1:0] ENT_END = ENT_BASE + DATA_W'(2 * NUM_ENTRIES);

  logic [DATA_W-1:0] rel;

  always_comb begin
    rel     = sel - ENT_BASE;
    ent_idx = rel[IDX_W:1];
    if (sel == DATA_W'(0))                        kind = K_ID;
    else if (sel == DATA_W'(1))                   kind = K_VER;
    else if (sel == DATA_W'(2))                   kind = K_ARB;
    else if (sel >= ENT_BASE && sel < ENT_END)    kind = rel[0] ? K_ENT_HI : K_ENT_LO;
    else                                          kind = K_NONE;
  end
endmodule

// File: rtl/irq_rf_entry_store.sv
module irq_rf_entry_store #(
  parameter int DATA_W      = 32,
  parameter int NUM_ENTRIES = 24,
  parameter logic [DATA_W-1:0] RESET_LO = 'h0001_0000,
  parameter logic [DATA_W-1:0] RESET_HI = 'h0,
  parameter logic [DATA_W-1:0] RO_MASK  = 'h0000_5000,
  localparam int IDX_W = $clog2(NUM_ENTRIES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              wr_hi,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_lo,
  output logic [DATA_W-1:0] rd_hi
);
  logic [DATA_W-1:0] lo_q [NUM_ENTRIES];
  logic [DATA_W-1:0] hi_q [NUM_ENTRIES];

  for (genvar n = 0; n < NUM_ENTRIES; n++) begin : g_ent
    logic hit;
    assign hit = wr_en && (wr_idx == IDX_W'(n));

    always_ff @(posedge clk) begin
      if (rst) begin
        lo_q[n] <= RESET_LO;
        hi_q[n] <= RESET_HI;
      end else if (hit) begin
        if (wr_hi) hi_q[n] <= wr_data;
        else       lo_q[n] <= (lo_q[n] & RO_MASK) | (wr_data & ~RO_MASK);
      end
    end
  end

  always_comb begin
    rd_lo = '0;
    rd_hi = '0;
    for (int n = 0; n < NUM_ENTRIES; n++) begin
      if (rd_idx == IDX_W'(n)) begin
        rd_lo = lo_q[n];
        rd_hi = hi_q[n];
      end
    end
  end
endmodule

// File: rtl/irq_route_regfile.sv
module irq_route_regfile
  import irq_rf_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int ADDR_W      = 8,
  parameter int SIZE_W      = 3,
  parameter int NUM_ENTRIES = 24,
  parameter int ID_W        = 4,
  parameter int ID_LSB      = 24,
  parameter logic [DATA_W-1:0] VERSION = 'h0017_0011,
  localparam int IDX_W = $clog2(NUM_ENTRIES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [SIZE_W-1:0] bus_size,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              rvalid,
  output logic              upd_valid,
  output logic [IDX_W-1:0]  upd_index
);
  logic              sel_wr, win_wr, rd_req, rd_sel, rd_win;
  logic [DATA_W-1:0] sel_q;
  logic [ID_W-1:0]   id_q;
  sel_kind_e         kind;
  logic [IDX_W-1:0]  ent_idx;
  logic              ent_wr;
  logic [DATA_W-1:0] ent_lo, ent_hi;
  logic [DATA_W-1:0] win_val;
  logic [DATA_W-1:0] id_word;

  irq_rf_bus_decode #(
    .ADDR_W(ADDR_W), .SIZE_W(SIZE_W), .BYTES(DATA_W / 8)
  ) bus_dec_i (
    .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
    .bus_size(bus_size), .sel_wr(sel_wr), .win_wr(win_wr),
    .rd_req(rd_req), .rd_sel(rd_sel), .rd_win(rd_win)
  );

  irq_rf_index_decode #(
    .DATA_W(DATA_W), .NUM_ENTRIES(NUM_ENTRIES)
  ) idx_dec_i (
    .sel(sel_q), .kind(kind), .ent_idx(ent_idx)
  );

  assign ent_wr = win_wr && (kind == K_ENT_LO || kind == K_ENT_HI);

  irq_rf_entry_store #(
    .DATA_W(DATA_W), .NUM_ENTRIES(NUM_ENTRIES)
  ) store_i (
    .clk(clk), .rst(rst), .wr_en(ent_wr), .wr_hi(kind == K_ENT_HI),
    .wr_idx(ent_idx), .wr_data(bus_wdata), .rd_idx(ent_idx),
    .rd_lo(ent_lo), .rd_hi(ent_hi)
  );

  always_comb begin
    id_word = '0;
    id_word[ID_LSB +: ID_W] = id_q;
    unique case (kind)
      K_ID, K_ARB: win_val = id_word;
      K_VER:       win_val = VERSION;
      K_ENT_LO:    win_val = ent_lo;
      K_ENT_HI:    win_val = ent_hi;
      default:     win_val = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q     <= '0;
      id_q      <= '0;
      rdata     <= '0;
      rvalid    <= 1'b0;
      upd_valid <= 1'b0;
      upd_index <= '0;
    end else begin
      if (sel_wr) sel_q <= bus_wdata;
      if (win_wr && kind == K_ID) id_q <= bus_wdata[ID_LSB +: ID_W];
      rvalid    <= rd_req;
      rdata     <= rd_sel ? sel_q : (rd_win ? win_val : '0);
      upd_valid <= ent_wr;
      if (ent_wr) upd_index <= ent_idx;
    end
  end
endmodule

// File: rtl/irq_rf_checker.sv
module irq_rf_checker #(
  parameter int DATA_W      = 32,
  parameter int ADDR_W      = 8,
  parameter int SIZE_W      = 3,
  parameter int NUM_ENTRIES = 24,
  localparam int IDX_W = $clog2(NUM_ENTRIES)
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_valid,
  input logic              bus_write,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [SIZE_W-1:0] bus_size,
  input logic [DATA_W-1:0] rdata,
  input logic              rvalid,
  input logic              upd_valid,
  input logic [IDX_W-1:0]  upd_index
);
  a_r12_read_response: assert property (@(posedge clk) disable iff (rst)
    (bus_valid && !bus_write) |=> rvalid);

  a_r12_no_spurious_response: assert property (@(posedge clk) disable iff (rst)
    rvalid |-> $past(bus_valid && !bus_write));

  a_r3_bad_size_reads_zero: assert property (@(posedge clk) disable iff (rst)
    (bus_valid && !bus_write && bus_size != SIZE_W'(DATA_W / 8)) |=> (rdata == '0));

  a_r2_unmapped_reads_zero: assert property (@(posedge clk) disable iff (rst)
    (bus_valid && !bus_write && bus_addr != ADDR_W'('h00) && bus_addr != ADDR_W'('h10))
      |=> (rdata == '0));

  a_r10_pulse_cause: assert property (@(posedge clk) disable iff (rst)
    upd_valid |-> $past(bus_valid && bus_write && bus_addr == ADDR_W'('h10)
                        && bus_size == SIZE_W'(DATA_W / 8)));

  a_r10_index_in_range: assert property (@(posedge clk) disable iff (rst)
    upd_valid |-> (upd_index < IDX_W'(NUM_ENTRIES)));
endmodule

bind irq_route_regfile irq_rf_checker #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .SIZE_W(SIZE_W), .NUM_ENTRIES(NUM_ENTRIES)
) chk_i (
  .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_write(bus_write),
  .bus_addr(bus_addr), .bus_size(bus_size), .rdata(rdata), .rvalid(rvalid),
  .upd_valid(upd_valid), .upd_index(upd_index)
);

// File: tb/irq_route_regfile_tb.sv
module irq_route_regfile_tb_top;
  localparam int N = 24;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_valid = 1'b0;
  logic        bus_write = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [2:0]  bus_size = 3'd4;
  logic [31:0] bus_wdata = '0;
  logic [31:0] rdata;
  logic        rvalid;
  logic        upd_valid;
  logic [4:0]  upd_index;

  int checks = 0;
  int errors = 0;
  logic        got_upd;
  logic [4:0]  got_idx;
  logic [31:0] got_data;
  logic        got_rv;

  always #2 clk = ~clk;

  irq_route_regfile dut_i (
    .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_size(bus_size), .bus_wdata(bus_wdata),
    .rdata(rdata), .rvalid(rvalid), .upd_valid(upd_valid), .upd_index(upd_index)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic bwr(input logic [7:0] a, input logic [31:0] d, input logic [2:0] s);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d; bus_size = s;
    @(negedge clk);
    got_upd = upd_valid; got_idx = upd_index;
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic brd(input logic [7:0] a, input logic [2:0] s);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a; bus_size = s;
    @(negedge clk);
    got_data = rdata; got_rv = rvalid;
    bus_valid = 1'b0;
  endtask

  task automatic win_wr(input logic [31:0] idx, input logic [31:0] d);
    bwr(8'h00, idx, 3'd4);
    bwr(8'h10, d, 3'd4);
  endtask

  task automatic win_rd(input logic [31:0] idx);
    bwr(8'h00, idx, 3'd4);
    brd(8'h10, 3'd4);
  endtask

  function automatic logic [31:0] lo_pat(input int n);
    return 32'hFFFF_F0F0 ^ (32'(n) * 32'h0101_0101);
  endfunction

  function automatic logic [31:0] hi_pat(input int n);
    return 32'h8000_0001 | (32'(n) << 8) | (32'(n) << 24);
  endfunction

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog: actual 0x%08h expected 0x%08h", 32'd1, 32'd0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    check("R1 upd_valid after reset", 32'(upd_valid), 32'd0);
    brd(8'h00, 3'd4);
    check("R1 selector reset", got_data, 32'h0);
    check("R12 rvalid", 32'(got_rv), 32'd1);
    win_rd(32'h0);
    check("R1 id reset", got_data, 32'h0);
    for (int n = 0; n < N; n++) begin
      win_rd(32'h10 + 32'(2 * n));
      check("R1 R4 entry low reset", got_data, 32'h0001_0000);
      win_rd(32'h11 + 32'(2 * n));
      check("R1 R4 entry high reset", got_data, 32'h0);
    end

    // R5 low writes protect bits 12 and 14; R10 pulse
    for (int n = 0; n < N; n++) begin
      win_wr(32'h10 + 32'(2 * n), lo_pat(n));
      check("R10 pulse valid", 32'(got_upd), 32'd1);
      check("R10 pulse index", 32'(got_idx), 32'(n));
      @(negedge clk);
      check("R10 pulse one cycle", 32'(upd_valid), 32'd0);
    end
    for (int n = 0; n < N; n++) begin
      win_rd(32'h10 + 32'(2 * n));
      check("R5 low half readback", got_data, lo_pat(n) & ~32'h0000_5000);
      win_rd(32'h11 + 32'(2 * n));
      check("R5 high half untouched", got_data, 32'h0);
    end

    // R6 high writes
    for (int n = 0; n < N; n++) begin
      win_wr(32'h11 + 32'(2 * n), hi_pat(n));
      check("R10 high pulse index", 32'(got_idx), 32'(n));
    end
    for (int n = 0; n < N; n++) begin
      win_rd(32'h11 + 32'(2 * n));
      check("R6 high half readback", got_data, hi_pat(n));
      win_rd(32'h10 + 32'(2 * n));
      check("R6 low half kept", got_data, lo_pat(n) & ~32'h0000_5000);
    end

    // R7 identification
    win_wr(32'h0, 32'hFFFF_FFFF);
    check("R7 id write no pulse", 32'(got_upd), 32'd0);
    win_rd(32'h0);
    check("R7 id readback", got_data, 32'h0F00_0000);
    win_rd(32'h2);
    check("R7 arbitration mirror", got_data, 32'h0F00_0000);
    win_wr(32'h0, 32'h5A00_0000);
    win_rd(32'h0);
    check("R7 id field only", got_data, 32'h0A00_0000);

    // R8 version
    win_rd(32'h1);
    check("R8 version", got_data, 32'h0017_0011);
    win_wr(32'h1, 32'h0);
    check("R8 version write no pulse", 32'(got_upd), 32'd0);
    win_rd(32'h1);
    check("R8 version after write", got_data, 32'h0017_0011);
    win_rd(32'h0);
    check("R8 id untouched", got_data, 32'h0A00_0000);

    // R9 undefined indices
    win_rd(32'h3);   check("R9 read 0x03", got_data, 32'h0);
    win_rd(32'h0F);  check("R9 read 0x0F", got_data, 32'h0);
    win_rd(32'h40);  check("R9 read 0x40", got_data, 32'h0);
    win_rd(32'h1000_0010); check("R9 read wide selector", got_data, 32'h0);
    win_wr(32'h40, 32'h1234_5678);
    check("R9 write 0x40 no pulse", 32'(got_upd), 32'd0);
    win_wr(32'h1000_0010, 32'h1234_5678);
    check("R9 write wide no pulse", 32'(got_upd), 32'd0);
    win_wr(32'h3, 32'hFFFF_FFFF);
    win_rd(32'h10); check("R9 entry 0 unchanged", got_data, lo_pat(0) & ~32'h0000_5000);
    win_rd(32'h3F); check("R9 entry 23 high unchanged", got_data, hi_pat(23));
    win_rd(32'h0);  check("R9 id unchanged", got_data, 32'h0A00_0000);

    // R3 bad sizes
    bwr(8'h00, 32'h10, 3'd4);
    bwr(8'h10, 32'hDEAD_BEEF, 3'd2);
    check("R3 bad size write no pulse", 32'(got_upd), 32'd0);
    bwr(8'h00, 32'h11, 3'd1);
    brd(8'h00, 3'd4);
    check("R3 bad size selector kept", got_data, 32'h10);
    brd(8'h10, 3'd4);
    check("R3 entry unchanged", got_data, lo_pat(0) & ~32'h0000_5000);
    brd(8'h10, 3'd2);
    check("R3 bad size read zero", got_data, 32'h0);
    check("R12 bad size rvalid", 32'(got_rv), 32'd1);
    brd(8'h00, 3'd0);
    check("R3 bad size selector read zero", got_data, 32'h0);

    // R2 unmapped offsets
    bwr(8'h04, 32'h11, 3'd4);
    bwr(8'h14, 32'h0, 3'd4);
    check("R2 unmapped write no pulse", 32'(got_upd), 32'd0);
    brd(8'h00, 3'd4);
    check("R2 selector unchanged", got_data, 32'h10);
    brd(8'h10, 3'd4);
    check("R2 entry unchanged", got_data, lo_pat(0) & ~32'h0000_5000);
    brd(8'h04, 3'd4);
    check("R2 unmapped read zero", got_data, 32'h0);
    brd(8'h20, 3'd4);
    check("R2 unmapped read zero 0x20", got_data, 32'h0);

    // R11 selector full readback
    bwr(8'h00, 32'hDEAD_BEEF, 3'd4);
    brd(8'h00, 3'd4);
    check("R11 selector readback", got_data, 32'hDEAD_BEEF);
    @(negedge clk);
    check("R12 rvalid drops", 32'(rvalid), 32'd0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule